// File: doc/BRIEF.md
# PCI Configuration Access Translator

This block sits between a local bus and a PCI master engine. It turns one configuration-window access from a local requester into one PCI configuration cycle. The requester gives the device/function number and a register offset. The target bus number comes from a field in a control register. The block forms the PCI address and selects IDSEL on bus 0 by shifting the device number up. A dedicated path reaches the bridge's own configuration header. Data is byte-swapped between the big-endian local side and the little-endian PCI side.

Completion is recorded in a status register that software polls. A "done" flag is set when the access ends. An "error" flag is set when no target answered. Both flags are cleared by writing ones to them. An access is held back while a DMA transfer owns the PCI bus. Accesses to device numbers above 15 never reach the bus.

Top module: `pci_cfg_xlat`

## Requirements
- R1: After reset the control register, the status register, `pci_cyc` and `cfg_done` are all zero.
- R2: Register select 0 reads and fully writes the control register. Select 2 writes only control bits [23:16], the bus number, from `reg_wdata[7:0]`, and reads them back in bits [7:0]. All other control bits are kept.
- R3: For a non-zero bus number, `pci_addr` equals BASE_ADDR OR (devfn << 8) OR the offset with bits [1:0] cleared. Here devfn is `cfg_addr[15:8]` and the offset is `cfg_addr[7:0]`. `pci_bus` carries control bits [23:16] and `pci_we` follows `cfg_we`.
- R4: When the bus number is 0, the devfn placed in the address is devfn + 48, so device 0 drives AD16 as IDSEL.
- R5: With `cfg_own` high the access goes to bus 0, devfn 0 (no +48), keeping only the offset, whatever the devfn bits and the bus field hold.
- R6: Status bit 20 (done) is set in the cycle `cfg_done` pulses. Writing a 1 to status bit 20 or bit 19 through select 1 clears that bit.
- R7: Status bit 19 (error) is set when the access ends in master abort, and such a read returns 0xFFFFFFFF on `cfg_rdata`.
- R8: Data is byte-reversed in both directions: `pci_wdata` is `cfg_wdata` with bytes reversed, and `cfg_rdata` is `pci_rdata` with bytes reversed.
- R9: If `cfg_addr[15]` is set (device 16 or above) and `cfg_own` is low, no PCI cycle runs. A read returns all ones, a write is dropped, and done is set with error clear.
- R10: A cycle with no `pci_ack` for TIMEOUT (5) consecutive `pci_cyc` cycles is ended as a master abort. An ack in the fifth cycle still completes normally.
- R11: `pci_cyc` does not rise while `dma_busy` was high in the previous cycle. It rises in the cycle after `dma_busy` is seen low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_sel | input | 2 | Register select: 0 control, 1 status, 2 bus-number field |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| cfg_req | input | 1 | Start a configuration access (taken when idle) |
| cfg_own | input | 1 | Target the bridge's own header |
| cfg_we | input | 1 | 1 = write, 0 = read |
| cfg_addr | input | 16 | Local window address: devfn [15:8], offset [7:0] |
| cfg_wdata | input | 32 | Local write data, big-endian |
| cfg_rdata | output | 32 | Read result, valid with cfg_done |
| cfg_done | output | 1 | One-cycle completion pulse |
| dma_busy | input | 1 | DMA owns the PCI bus |
| pci_cyc | output | 1 | Configuration cycle in progress |
| pci_we | output | 1 | Cycle is a write |
| pci_bus | output | 8 | Target bus number |
| pci_addr | output | 32 | Configuration address |
| pci_wdata | output | 32 | Write data, little-endian |
| pci_ack | input | 1 | Target claimed and finished the cycle |
| pci_rdata | input | 32 | Read data from target, little-endian |

## Verification
Several kinds of access are driven: reads and writes on a non-zero bus, on bus 0, on the own-header path, and at device 16. Comparing the address seen on the PCI side across these separates the +48 offset from the plain path and from the forced bus 0/devfn 0 path. Responder latency is swept from an immediate ack to an ack in the last allowed cycle and to no ack. This separates a normal completion from the timeout boundary, and both from a master abort with its all-ones read. Stalled starts with DMA held busy show that the cycle waits for the bus. Distinct byte patterns in both directions expose any lane-order error.

// File: rtl/pci_cfg_xlat.sv
module pci_cfg_xlat #(
  parameter logic [31:0] BASE_ADDR = 32'h8001_0000,
  parameter int TIMEOUT = 5,
  parameter int BUS0_OFS = 48
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [1:0]  reg_sel,
  input  logic        reg_we,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  input  logic        cfg_req,
  input  logic        cfg_own,
  input  logic        cfg_we,
  input  logic [15:0] cfg_addr,
  input  logic [31:0] cfg_wdata,
  output logic [31:0] cfg_rdata,
  output logic        cfg_done,
  input  logic        dma_busy,
  output logic        pci_cyc,
  output logic        pci_we,
  output logic [7:0]  pci_bus,
  output logic [31:0] pci_addr,
  output logic [31:0] pci_wdata,
  input  logic        pci_ack,
  input  logic [31:0] pci_rdata
);
  localparam int CW = $clog2(TIMEOUT + 1);
  localparam logic [CW-1:0] CLAST = CW'(TIMEOUT - 1);

  typedef enum logic [1:0] {IDLE, STALL, BUSY, FIN} st_t;
  st_t state;

  logic [31:0] ctrl;
  logic        st_valid, st_err;
  logic [CW-1:0] cnt;
  logic [7:0]  lat_devfn, lat_bus;
  logic [5:0]  lat_off;
  logic        lat_we;
  logic [31:0] lat_wdata, rdata_q;

  function automatic logic [31:0] swap32(input logic [31:0] d);
    return {d[7:0], d[15:8], d[23:16], d[31:24]};
  endfunction

  wire take    = (state == IDLE) && cfg_req;
  wire drop    = !cfg_own && cfg_addr[15];
  wire bus_end = (state == BUSY) && (pci_ack || cnt == CLAST);
  wire fin_set = (take && drop) || bus_end;
  wire abort   = (state == BUSY) && !pci_ack;
  wire [7:0] cur_bus = ctrl[23:16];

  always_comb begin
    case (reg_sel)
      2'd0:    reg_rdata = ctrl;
      2'd1:    reg_rdata = {11'd0, st_valid, st_err, 19'd0};
      2'd2:    reg_rdata = {24'd0, cur_bus};
      default: reg_rdata = 32'd0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) ctrl <= '0;
    else if (reg_we && reg_sel == 2'd0) ctrl <= reg_wdata;
    else if (reg_we && reg_sel == 2'd2) ctrl[23:16] <= reg_wdata[7:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_valid <= 1'b0;
      st_err   <= 1'b0;
    end else begin
      if (reg_we && reg_sel == 2'd1) begin
        if (reg_wdata[20]) st_valid <= 1'b0;
        if (reg_wdata[19]) st_err   <= 1'b0;
      end
      if (fin_set) begin
        st_valid <= 1'b1;
        st_err   <= abort;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= IDLE;
      cnt       <= '0;
      lat_devfn <= '0;
      lat_bus   <= '0;
      lat_off   <= '0;
      lat_we    <= 1'b0;
      lat_wdata <= '0;
      rdata_q   <= '0;
    end else begin
      case (state)
        IDLE: if (cfg_req) begin
          lat_we    <= cfg_we;
          lat_off   <= cfg_addr[7:2];
          lat_wdata <= swap32(cfg_wdata);
          lat_bus   <= cfg_own ? 8'd0 : cur_bus;
          if (cfg_own) lat_devfn <= 8'd0;
          else if (cur_bus == 8'd0) lat_devfn <= cfg_addr[15:8] + 8'(BUS0_OFS);
          else lat_devfn <= cfg_addr[15:8];
          if (drop) begin
            rdata_q <= '1;
            state   <= FIN;
          end else state <= STALL;
        end
        STALL: if (!dma_busy) begin
          cnt   <= '0;
          state <= BUSY;
        end
        BUSY: begin
          if (pci_ack) begin
            rdata_q <= swap32(pci_rdata);
            state   <= FIN;
          end else if (cnt == CLAST) begin
            rdata_q <= '1;
            state   <= FIN;
          end else cnt <= cnt + 1'b1;
        end
        default: state <= IDLE;
      endcase
    end
  end

  assign cfg_done  = (state == FIN);
  assign cfg_rdata = rdata_q;
  assign pci_cyc   = (state == BUSY);
  assign pci_we    = lat_we;
  assign pci_bus   = lat_bus;
  assign pci_addr  = BASE_ADDR | {16'd0, lat_devfn, 8'd0} | {24'd0, lat_off, 2'b00};
  assign pci_wdata = lat_wdata;
endmodule

// File: rtl/pci_cfg_xlat_chk.sv
module pci_cfg_xlat_chk #(
  parameter int TIMEOUT = 5
) (
  input logic        clk,
  input logic        rst_n,
  input logic [1:0]  reg_sel,
  input logic        reg_we,
  input logic        cfg_req,
  input logic        cfg_own,
  input logic        cfg_we,
  input logic [15:0] cfg_addr,
  input logic [31:0] cfg_rdata,
  input logic        cfg_done,
  input logic        dma_busy,
  input logic        pci_cyc,
  input logic        pci_ack,
  input logic [31:0] ctrl,
  input logic        st_valid,
  input logic        st_err
);
  int run;
  logic rd_pend, busy_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run <= 0;
      rd_pend <= 1'b0;
      busy_q <= 1'b0;
    end else begin
      run <= (pci_cyc && !pci_ack) ? run + 1 : 0;
      if (cfg_req && !busy_q) rd_pend <= !cfg_we;
      if (cfg_req && !busy_q) busy_q <= 1'b1;
      else if (cfg_done) busy_q <= 1'b0;
    end
  end

  AST_BUSFIELD_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_sel == 2'd2) |=> (ctrl[15:0] == $past(ctrl[15:0]) && ctrl[31:24] == $past(ctrl[31:24]))); // R2
  AST_DONE_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_done |-> st_valid); // R6
  AST_ABORT_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_done && st_err && rd_pend) |-> cfg_rdata == 32'hFFFF_FFFF); // R7
  AST_HIGH_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_req && !busy_q && !cfg_own && cfg_addr[15]) |=> !pci_cyc); // R9
  AST_TIMEOUT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    pci_cyc |-> run < TIMEOUT); // R10
  AST_ABORT_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(pci_cyc) && !$past(pci_ack)) |-> st_err); // R7
  AST_DMA_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pci_cyc) |-> !$past(dma_busy)); // R11
endmodule

bind pci_cfg_xlat pci_cfg_xlat_chk #(.TIMEOUT(TIMEOUT)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_we(reg_we),
  .cfg_req(cfg_req), .cfg_own(cfg_own), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
  .cfg_rdata(cfg_rdata), .cfg_done(cfg_done), .dma_busy(dma_busy),
  .pci_cyc(pci_cyc), .pci_ack(pci_ack), .ctrl(ctrl),
  .st_valid(st_valid), .st_err(st_err));

// File: tb/pci_cfg_xlat_test.sv
`timescale 1ns/1ps
module pci_cfg_xlat_test;
  localparam logic [31:0] BASE = 32'h8001_0000;
  logic clk = 0, rst_n = 0;
  logic [1:0] reg_sel = 0; logic reg_we = 0; logic [31:0] reg_wdata = 0, reg_rdata;
  logic cfg_req = 0, cfg_own = 0, cfg_we = 0; logic [15:0] cfg_addr = 0;
  logic [31:0] cfg_wdata = 0, cfg_rdata; logic cfg_done;
  logic dma_busy = 0, pci_cyc, pci_we, pci_ack = 0;
  logic [7:0] pci_bus; logic [31:0] pci_addr, pci_wdata, pci_rdata = 0;
  int n_chk = 0, n_fail = 0;
  int rsp_delay = 0, bcnt = 0;
  logic [31:0] rsp_data = 0;
  logic [7:0] mbus = 0;

  always #2.5 clk = ~clk;

  pci_cfg_xlat #(.BASE_ADDR(BASE)) uut (.*);

  always @(negedge clk) begin
    if (pci_cyc) begin
      pci_ack   = (bcnt == rsp_delay);
      pci_rdata = rsp_data;
      bcnt++;
    end else begin
      pci_ack = 0;
      bcnt = 0;
    end
  end

  function automatic logic [31:0] sw(input logic [31:0] d);
    return {d[7:0], d[15:8], d[23:16], d[31:24]};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic rd_reg(input logic [1:0] s, input logic [31:0] exp, input string tag);
    reg_sel = s; #0.1;
    chk(reg_rdata === exp, tag, reg_rdata, exp);
  endtask

  task automatic wr_reg(input logic [1:0] s, input logic [31:0] d);
    reg_sel = s; reg_we = 1; reg_wdata = d;
    if (s == 0) mbus = d[23:16];
    if (s == 2) mbus = d[7:0];
    @(negedge clk); reg_we = 0;
  endtask

  task automatic acc(input bit own, input bit we, input logic [15:0] a, input logic [31:0] wd,
                     input int delay, input int stall, input logic [31:0] rsp, input string tag);
    bit drop, ab, seen;
    int t, ncyc, rel;
    logic [7:0] ed, eb;
    logic [31:0] ea;
    drop = !own && a[15];
    ab = !drop && (delay < 0 || delay >= 5);
    eb = own ? 8'd0 : mbus;
    ed = own ? 8'd0 : (mbus == 0 ? a[15:8] + 8'd48 : a[15:8]);
    ea = BASE | {16'd0, ed, 8'd0} | {24'd0, a[7:2], 2'b00};
    rsp_delay = (delay < 0) ? 99 : delay; rsp_data = rsp;
    dma_busy = (stall > 0); rel = 0;
    cfg_req = 1; cfg_own = own; cfg_we = we; cfg_addr = a; cfg_wdata = wd;
    @(negedge clk); cfg_req = 0;
    t = 0; ncyc = 0; seen = 0;
    while (t < 100) begin
      t++;
      if (pci_cyc) begin
        ncyc++;
        chk(rel < t, {tag, " R11 start after dma release"}, t, rel + 1);
        if (!seen) begin
          seen = 1;
          chk(pci_addr === ea, {tag, " R3/R4/R5 pci_addr"}, pci_addr, ea);
          chk(pci_bus === eb, {tag, " R3/R5 pci_bus"}, {24'd0, pci_bus}, {24'd0, eb});
          chk(pci_we === we, {tag, " R3 pci_we"}, {31'd0, pci_we}, {31'd0, we});
          if (we) chk(pci_wdata === sw(wd), {tag, " R8 pci_wdata"}, pci_wdata, sw(wd));
        end
      end
      if (cfg_done) break;
      if (t == stall) begin dma_busy = 0; rel = t; end
      @(negedge clk);
    end
    chk(cfg_done === 1'b1, {tag, " R6 done seen"}, {31'd0, cfg_done}, 1);
    chk(ncyc == (drop ? 0 : ab ? 5 : delay + 1), {tag, " R9/R10 bus cycles"}, ncyc,
        drop ? 0 : ab ? 5 : delay + 1);
    if (!we) begin
      if (drop || ab) chk(cfg_rdata === 32'hFFFF_FFFF, {tag, " R7/R9 ones"}, cfg_rdata, 32'hFFFF_FFFF);
      else chk(cfg_rdata === sw(rsp), {tag, " R8 cfg_rdata"}, cfg_rdata, sw(rsp));
    end
    rd_reg(1, {11'd0, 1'b1, ab, 19'd0}, {tag, " R6/R7 status"});
    wr_reg(1, 32'h0018_0000);
    rd_reg(1, 32'd0, {tag, " R6 w1c"});
    dma_busy = 0;
  endtask

  initial begin
    #(200000 * 5);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    rd_reg(0, 0, "R1 ctrl reset");
    rd_reg(1, 0, "R1 status reset");
    chk(pci_cyc === 0 && cfg_done === 0, "R1 idle outputs", {30'd0, pci_cyc, cfg_done}, 0);
    wr_reg(0, 32'hA5A5_A5A5);
    rd_reg(0, 32'hA5A5_A5A5, "R2 full write");
    wr_reg(2, 32'h0000_0003);
    rd_reg(0, 32'hA503_A5A5, "R2 bus field only");
    rd_reg(2, 32'h0000_0003, "R2 bus readback");
    acc(0, 0, 16'h290E, 0, 2, 0, 32'h1122_3344, "R3 read bus3");
    acc(0, 1, 16'h2904, 32'hDEAD_BEEF, 0, 0, 0, "R8 write bus3");
    acc(1, 0, 16'h4810, 0, 1, 0, 32'hCAFE_0001, "R5 own header");
    acc(1, 0, 16'hF83C, 0, 0, 0, 32'h0102_0304, "R5 own high devfn");
    wr_reg(2, 32'h0000_0000);
    acc(0, 0, 16'h0808, 0, 1, 0, 32'h5566_7788, "R4 bus0 dev1");
    acc(0, 1, 16'h7800, 32'h0BAD_F00D, 3, 0, 0, "R4 bus0 dev15 write");
    acc(0, 0, 16'h0000, 0, -1, 0, 0, "R7 R10 master abort");
    acc(0, 0, 16'h0004, 0, 4, 0, 32'h9ABC_DEF0, "R10 ack last cycle");
    acc(0, 0, 16'h8004, 0, 0, 0, 0, "R9 slot16 read");
    acc(0, 1, 16'hF800, 32'h1234_5678, 0, 0, 0, "R9 slot31 write");
    wr_reg(2, 32'h0000_0007);
    acc(0, 0, 16'h1010, 0, 0, 4, 32'h0F0E_0D0C, "R11 dma stall");
    acc(0, 0, 16'h1010, 0, -1, 2, 0, "R11 R7 stall then abort");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule